// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps the interrupt flags and interrupt enables for one 16-bit timer/counter. The timer core sends it single-cycle strobes: capture, counter at TOP, compare match on channels A, B and C, forced-compare strobes, and overflow. The block turns these strobes into sticky flags. Software clears a flag by writing a one to its bit on a small register port. A flag also clears when the CPU acknowledges that source's interrupt vector.

Each source has its own interrupt request. A request is raised only when the source's flag is set, its enable bit is set and the global enable input is high. A compare match is registered on one timer tick and becomes a flag on the next tick. The `tick_i` input is the prescaler clock-enable. Overflow and TOP events are also counted only on ticks. Capture events are taken on any system clock.

Source index order for `ack_i` and `irq_o`: 0 overflow, 1 compare A, 2 compare B, 3 compare C, 4 capture.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset, all flags and enables are 0, both registers read 0x00 and `irq_o` is 0.
- R2: In the flag register (address 0), bit 0 is overflow, bit 1 is compare A, bit 2 is compare B, bit 3 is compare C and bit 5 is capture. Bits 7, 6 and 4 always read 0.
- R3: A compare match presented with `tick_i` high is held. It sets the channel flag on the next clock edge at which `tick_i` is high, never on the edge that sampled the match. Cycles without a tick in between delay the flag.
- R4: A match whose forced-compare strobe is high in the same sampled tick never sets that channel's flag.
- R5: `cap_evt_i` sets the capture flag at the next clock edge, whatever the value of `tick_i`.
- R6: `top_evt_i` with `tick_i` sets the capture flag at the next edge only when `cap_is_top_i` is 1.
- R7: `ovf_evt_i` with `tick_i` sets the overflow flag at the next edge.
- R8: A write to address 0 clears each flag whose bit is written 1. Bits written 0 are left unchanged.
- R9: `ack_i[k]` clears flag k at the next edge and no other flag.
- R10: When a set and a clear (write-one or acknowledge) hit the same flag in one cycle, the flag ends up set.
- R11: `irq_o[k]` = flag k AND enable k AND `gie_i`, combinationally.
- R12: The enable register (address 1) uses the flag bit positions and is read/write on bits 0-3 and 5. Its other bits read 0.
- R13: Overflow, TOP and compare strobes seen while `tick_i` is 0 set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer clock-enable (prescaler tick) |
| cap_evt_i | input | 1 | Input capture event strobe |
| top_evt_i | input | 1 | Counter reached TOP |
| cap_is_top_i | input | 1 | Waveform mode uses the capture register as TOP |
| cmp_match_i | input | 3 | Compare match strobes, bit 0 = A, bit 2 = C |
| force_cmp_i | input | 3 | Forced-compare strobes, same order |
| ovf_evt_i | input | 1 | Counter overflow strobe |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | 0 = flags, 1 = enables |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |
| ack_i | input | 5 | Vector acknowledge, one bit per source |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 5 | Interrupt request per source |

## Verification
Most flag updates appear one clock edge after the stimulus. Capture, overflow, TOP, write-one-to-clear and acknowledge all follow this rule. Compare flags take two tick-qualified edges. The requests and the read data follow the flag state with no added delay.

The bench drives inputs on the falling edge and advances a reference model at the rising edge. It samples 5 ns after that edge. The compare delay is checked directly: the flag is read once after the first tick edge, where it must be clear, and again after gap cycles and the second tick edge, where it must be set.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int unsigned NUM_SRC = 5;
  localparam int unsigned NUM_CMP = 3;
  localparam int unsigned REG_W   = 8;

  localparam int unsigned SRC_OVF = 0;
  localparam int unsigned SRC_CMP = 1;  // first compare channel
  localparam int unsigned SRC_CAP = SRC_CMP + NUM_CMP;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  // bit position of each source in the register byte
  function automatic int unsigned src_pos(int unsigned idx);
    return (idx == SRC_CAP) ? 5 : idx;
  endfunction
endpackage

// File: rtl/tmr_evt_qual.sv
module tmr_evt_qual
  import tmr_irq_pkg::*;
#(
  parameter int unsigned N_CMP = NUM_CMP
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [N_CMP-1:0] cmp_match_i,
  input  logic [N_CMP-1:0] force_cmp_i,
  input  logic             ovf_evt_i,
  input  logic             top_evt_i,
  input  logic             cap_is_top_i,
  input  logic             cap_evt_i,
  output src_vec_t         set_o
);
  logic [N_CMP-1:0] pend_q;

  for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
    // match sampled on one tick, flagged on the next
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pend_q[c] <= 1'b0;
      else if (tick_i) pend_q[c] <= cmp_match_i[c] & ~force_cmp_i[c];
    end
    assign set_o[SRC_CMP+c] = tick_i & pend_q[c];
  end

  assign set_o[SRC_OVF] = tick_i & ovf_evt_i;
  assign set_o[SRC_CAP] = cap_evt_i | (tick_i & top_evt_i & cap_is_top_i);
endmodule

// File: rtl/tmr_flag_bank.sv
module tmr_flag_bank
  import tmr_irq_pkg::*;
#(
  parameter int unsigned N = NUM_SRC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    // set dominates clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[i] <= 1'b0;
      else if (set_i[i]) flag_o[i] <= 1'b1;
      else if (clr_i[i]) flag_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_reg_port.sv
module tmr_reg_port
  import tmr_irq_pkg::*;
#(
  parameter int unsigned N = NUM_SRC,
  parameter int unsigned W = REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic         addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [N-1:0] flag_i,
  output logic [N-1:0] w1c_o,
  output logic [N-1:0] en_o,
  output logic [W-1:0] rdata_o
);
  logic [N-1:0] wsrc;
  logic [W-1:0] flag_byte, en_byte;

  for (genvar i = 0; i < N; i++) begin : g_map
    localparam int unsigned P = src_pos(i);
    assign wsrc[i] = wdata_i[P];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               en_o[i] <= 1'b0;
      else if (we_i && addr_i)   en_o[i] <= wsrc[i];
    end
  end

  always_comb begin
    flag_byte = '0;
    en_byte   = '0;
    for (int unsigned i = 0; i < N; i++) begin
      flag_byte[src_pos(i)] = flag_i[i];
      en_byte[src_pos(i)]   = en_o[i];
    end
  end

  assign w1c_o   = (we_i && !addr_i) ? wsrc : '0;
  assign rdata_o = addr_i ? en_byte : flag_byte;
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tmr_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               cap_evt_i,
  input  logic               top_evt_i,
  input  logic               cap_is_top_i,
  input  logic [NUM_CMP-1:0] cmp_match_i,
  input  logic [NUM_CMP-1:0] force_cmp_i,
  input  logic               ovf_evt_i,
  input  logic               bus_we_i,
  input  logic               bus_addr_i,
  input  logic [REG_W-1:0]   bus_wdata_i,
  output logic [REG_W-1:0]   bus_rdata_o,
  input  logic [NUM_SRC-1:0] ack_i,
  input  logic               gie_i,
  output logic [NUM_SRC-1:0] irq_o
);
  src_vec_t set_v, w1c_v, flag_q, en_q;

  tmr_evt_qual #(.N_CMP(NUM_CMP)) u_qual (
    .clk_i, .rst_ni, .tick_i, .cmp_match_i, .force_cmp_i, .ovf_evt_i,
    .top_evt_i, .cap_is_top_i, .cap_evt_i, .set_o(set_v)
  );

  tmr_flag_bank #(.N(NUM_SRC)) u_bank (
    .clk_i, .rst_ni, .set_i(set_v), .clr_i(w1c_v | ack_i), .flag_o(flag_q)
  );

  tmr_reg_port #(.N(NUM_SRC), .W(REG_W)) u_regs (
    .clk_i, .rst_ni, .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .flag_i(flag_q), .w1c_o(w1c_v), .en_o(en_q), .rdata_o(bus_rdata_o)
  );

  assign irq_o = flag_q & en_q & {NUM_SRC{gie_i}};
endmodule

// File: rtl/tmr_irq_flags_chk.sv
module tmr_irq_flags_chk
  import tmr_irq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic               cap_evt_i,
  input logic               ovf_evt_i,
  input logic               bus_we_i,
  input logic               bus_addr_i,
  input logic [REG_W-1:0]   bus_wdata_i,
  input logic [REG_W-1:0]   bus_rdata_o,
  input logic [NUM_SRC-1:0] ack_i,
  input logic               gie_i,
  input logic [NUM_SRC-1:0] irq_o,
  input logic [NUM_SRC-1:0] flag_q
);
  p_reserved_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[7:6] == 2'b00 && bus_rdata_o[4] == 1'b0);

  p_cap_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i |=> flag_q[SRC_CAP]);

  p_ovf_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && ovf_evt_i) |=> flag_q[SRC_OVF]);

  p_w1c_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && !bus_addr_i && bus_wdata_i[0] && !(tick_i && ovf_evt_i)) |=> !flag_q[SRC_OVF]);

  p_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i[SRC_OVF] && !(tick_i && ovf_evt_i)) |=> !flag_q[SRC_OVF]);

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && ovf_evt_i && ack_i[SRC_OVF]) |=> flag_q[SRC_OVF]);

  p_irq_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> gie_i);

  p_no_tick_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cap_evt_i && !bus_we_i && ack_i == '0) |=> $stable(flag_q));
endmodule

bind tmr_irq_flags tmr_irq_flags_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .cap_evt_i(cap_evt_i),
  .ovf_evt_i(ovf_evt_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .ack_i(ack_i),
  .gie_i(gie_i), .irq_o(irq_o), .flag_q(flag_q)
);

// File: tb/tmr_irq_flags_tb_top.sv
`timescale 1ns/1ps
module tmr_irq_flags_tb_top;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       tick, cap, top, cap_top, ovf, we, addr, gie;
  logic [2:0] match, frc;
  logic [7:0] wdata, rdata;
  logic [4:0] ack, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state
  logic [4:0] m_flag, m_en;
  logic [2:0] m_pend;

  always #10 clk = ~clk;

  tmr_irq_flags dut_i (
    .clk_i(clk), .rst_ni, .tick_i(tick), .cap_evt_i(cap), .top_evt_i(top),
    .cap_is_top_i(cap_top), .cmp_match_i(match), .force_cmp_i(frc),
    .ovf_evt_i(ovf), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .ack_i(ack), .gie_i(gie), .irq_o(irq)
  );

  function automatic logic [7:0] to_byte(logic [4:0] v);
    return {2'b00, v[4], 1'b0, v[3:0]};
  endfunction

  function automatic logic [4:0] from_byte(logic [7:0] b);
    return {b[5], b[3:0]};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    tick = 0; cap = 0; top = 0; cap_top = 0; ovf = 0; we = 0; addr = 0;
    wdata = 0; ack = 0; match = 0; frc = 0;
  endtask

  // apply driven inputs for one edge, update model, sample 5 ns later
  task automatic cycle();
    logic [4:0] set_v, clr_v, f_n, e_n;
    logic [2:0] p_n;
    set_v = {cap | (tick & top & cap_top), {3{tick}} & m_pend, tick & ovf};
    p_n   = tick ? (match & ~frc) : m_pend;
    clr_v = ack | ((we && !addr) ? from_byte(wdata) : 5'b0);
    f_n   = (m_flag & ~clr_v) | set_v;
    e_n   = (we && addr) ? from_byte(wdata) : m_en;
    @(posedge clk);
    m_flag = f_n; m_pend = p_n; m_en = e_n;
    #5;
    chk("R2/R12 rdata", rdata, addr ? to_byte(m_en) : to_byte(m_flag));
    chk("R11 irq", {3'b0, irq}, {3'b0, m_flag & m_en & {5{gie}}});
    @(negedge clk);
    idle();
  endtask

  task automatic rd(logic a, logic [7:0] exp, string req);
    addr = a; #1; chk(req, rdata, exp); addr = 0;
  endtask

  initial begin
    #(20ns * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(); gie = 0;
    m_flag = 0; m_en = 0; m_pend = 0;
    #35 rst_ni = 1;
    @(negedge clk);
    // R1 reset
    rd(0, 8'h00, "R1 flags"); rd(1, 8'h00, "R1 en");
    chk("R1 irq", {3'b0, irq}, 8'h00);

    // R12 enables, reserved bits read 0 (R2)
    we = 1; addr = 1; wdata = 8'hFF; cycle();
    rd(1, 8'h2F, "R12 en readback");
    we = 1; addr = 1; wdata = 8'h00; cycle();
    rd(1, 8'h00, "R12 en clear");

    // R13 no tick: nothing sets
    ovf = 1; top = 1; cap_top = 1; match = 3'b111; cycle();
    cycle(); rd(0, 8'h00, "R13 no tick");

    // R7 overflow
    tick = 1; ovf = 1; cycle(); rd(0, 8'h01, "R7 ovf -> bit0");

    // R3 compare A delay with gap
    tick = 1; match = 3'b001; cycle(); rd(0, 8'h01, "R3 not yet at first tick");
    cycle(); cycle(); rd(0, 8'h01, "R3 held through gap");
    tick = 1; cycle(); rd(0, 8'h03, "R3 set on second tick");

    // R4 forced compare on B, plain C
    tick = 1; match = 3'b110; frc = 3'b010; cycle();
    tick = 1; cycle(); rd(0, 8'h0B, "R4 B suppressed, C set");

    // R6 top without / with capture-as-top
    tick = 1; top = 1; cycle(); rd(0, 8'h0B, "R6 top ignored");
    tick = 1; top = 1; cap_top = 1; cycle(); rd(0, 8'h2B, "R6 top sets cap");

    // R8 w1c
    we = 1; wdata = 8'h22; cycle(); rd(0, 8'h09, "R8 clear A+cap only");
    we = 1; wdata = 8'h00; cycle(); rd(0, 8'h09, "R8 zero write no effect");

    // R5 capture without tick
    cap = 1; cycle(); rd(0, 8'h29, "R5 capture");

    // R9 ack clears only compare C
    ack = 5'b01000; cycle(); rd(0, 8'h21, "R9 ack C");

    // R10 set wins over ack and w1c
    tick = 1; ovf = 1; ack = 5'b00001; cycle(); rd(0, 8'h21, "R10 vs ack");
    cap = 1; we = 1; wdata = 8'h20; cycle(); rd(0, 8'h21, "R10 vs w1c");

    // R11 irq gating
    we = 1; addr = 1; wdata = 8'h20; cycle();
    #1 chk("R11 gie low", {3'b0, irq}, 8'h00);
    gie = 1; #1 chk("R11 gie high", {3'b0, irq}, 8'h10);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      tick = ($urandom % 3) == 0; cap = ($urandom % 9) == 0;
      top = ($urandom % 5) == 0;  cap_top = $urandom;
      ovf = ($urandom % 6) == 0;  match = $urandom; frc = $urandom;
      we = ($urandom % 5) == 0;   addr = $urandom; wdata = $urandom;
      ack = ($urandom % 4) == 0 ? 5'($urandom) : 5'b0;
      gie = ($urandom % 4) != 0;
      cycle();
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule